// File: doc/BRIEF.md
# Iterative Decimal Coefficient Multiplier

This block multiplies two unsigned decimal coefficients held as packed BCD, four bits per digit, and returns the full double-width BCD product. With the default sizing, each operand has 16 digits and the product has 32 digits. The multiplier operand is worked through one digit per clock, starting from the least significant digit. For each digit, the block adds a partial product to a decimal accumulator. That partial product is always the sum of two cheap multiples of the multiplicand. The first comes from {0, 2X, 5X, 10X} and the second from {0, +X, +2X, -X, -2X}. Because of this, the block never needs 3X, 4X or 7X to 9X.

2X and 5X are produced without carry chains by a per-digit doubler and quintupler, and 10X is a one-digit shift. A negative multiple enters the second adder as its nine's complement with a carry-in of one, and the carry out of the top digit is dropped. Leading zero digits of the multiplier are never iterated, so the latency follows the number of significant multiplier digits.

Operands enter through a valid/ready handshake. `in_ready` is low for the whole time an operation is in flight. That is the only back-pressure the block applies. A request held valid while the block is busy is neither captured nor queued, and it is accepted only on a cycle in which `in_ready` is high. The result side has no back-pressure. `done` pulses for one cycle, and `product` holds its value until the next operation completes.

Top module: `dec_mul_iter`

## Requirements
- R1: After reset, `busy` and `done` are 0, `in_ready` is 1 and `product` is all zeros.
- R2: When `done` pulses, `product` equals multiplicand times multiplier as a 32-digit BCD value. Digit k occupies bits [4k+3:4k] in every operand and in the product.
- R3: With N the number of multiplier digits at and below its highest nonzero digit (N = 0 for a zero multiplier), `done` is high in the cycle after the (N+1)-th rising edge that follows the accepting edge.
- R4: `in_ready` is the inverse of `busy`. `busy` rises on the edge that accepts a request and falls exactly when `done` is asserted.
- R5: `in_valid` asserted while `busy` is high has no effect. The running result is unchanged, and no further `done` follows.
- R6: `done` is high for exactly one cycle. `product` holds its value from that cycle until the next `done`.
- R7: Multiplier digits 8 and 9, which use negative multiples, give correct products. This includes an all-nines times all-nines operation.
- R8: A zero multiplicand or a zero multiplier yields an all-zero product.
- R9: Every product digit is a valid BCD value (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can accept an operand pair |
| multiplicand | input | 4*DIGITS | BCD multiplicand |
| multiplier | input | 4*DIGITS | BCD multiplier, scanned from digit 0 upward |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle pulse, product is valid |
| product | output | 8*DIGITS | BCD product |

## Verification
The bench checks latency for every operation, from a zero multiplier up to a full 16-digit one. A design that scans all digits, or that stops one digit early, misses the expected `done` cycle and also loses the top product digits.

Multiplier digits 8 and 9, including the all-nines case, exercise the ten's-complement path. A mishandled final carry or a wrong padding digit there would corrupt the upper digits.

The doubler and quintupler are stressed with multiplicands full of 5s and 9s, where a wrong cross-digit term gives a wrong digit.

Requests held valid during a run check that a block capturing operands while busy would report the wrong product or raise a second `done`.

// File: rtl/dmul_pkg.sv
package dmul_pkg;

  typedef logic [3:0] bcd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dmul_state_e;

  // first multiple: from the set {0, 2X, 5X, 10X}
  typedef enum logic [1:0] {
    HI_ZERO = 2'd0,
    HI_X2   = 2'd1,
    HI_X5   = 2'd2,
    HI_X10  = 2'd3
  } hi_sel_e;

  // magnitude of second multiple: {0, 1X, 2X}
  typedef enum logic [1:0] {
    LO_ZERO = 2'd0,
    LO_X1   = 2'd1,
    LO_X2   = 2'd2
  } lo_sel_e;

  typedef struct packed {
    hi_sel_e hi;
    lo_sel_e lo;
    logic    lo_neg;
  } pp_sel_t;

  // split one multiplier digit into two easy multiples
  function automatic pp_sel_t split_digit(input bcd_t d);
    pp_sel_t s;
    s = '{hi: HI_ZERO, lo: LO_ZERO, lo_neg: 1'b0};
    case (d)
      4'd1: s = '{hi: HI_ZERO, lo: LO_X1,   lo_neg: 1'b0};
      4'd2: s = '{hi: HI_X2,   lo: LO_ZERO, lo_neg: 1'b0};
      4'd3: s = '{hi: HI_X2,   lo: LO_X1,   lo_neg: 1'b0};
      4'd4: s = '{hi: HI_X2,   lo: LO_X2,   lo_neg: 1'b0};
      4'd5: s = '{hi: HI_X5,   lo: LO_ZERO, lo_neg: 1'b0};
      4'd6: s = '{hi: HI_X5,   lo: LO_X1,   lo_neg: 1'b0};
      4'd7: s = '{hi: HI_X5,   lo: LO_X2,   lo_neg: 1'b0};
      4'd8: s = '{hi: HI_X10,  lo: LO_X2,   lo_neg: 1'b1};
      4'd9: s = '{hi: HI_X10,  lo: LO_X1,   lo_neg: 1'b1};
      default: s = '{hi: HI_ZERO, lo: LO_ZERO, lo_neg: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dmul_multiples.sv
// Carry-free doubler and quintupler on a BCD vector.
// Digit i of 2X depends only on digits i and i-1 of X; the same holds for 5X.
module dmul_multiples #(
  parameter int DIGITS = 16
) (
  input  logic [4*DIGITS-1:0]     x,
  output logic [4*(DIGITS+1)-1:0] x2,
  output logic [4*(DIGITS+1)-1:0] x5
);
  localparam int PW = 4 * (DIGITS + 2);

  logic [PW-1:0] xp;
  assign xp = {4'h0, x, 4'h0};

  for (genvar i = 0; i <= DIGITS; i++) begin : g_dig
    logic [3:0] own;
    logic [3:0] low;
    logic [4:0] twice;
    logic [3:0] twice_mod;
    assign own       = xp[4*(i+1) +: 4];
    assign low       = xp[4*i +: 4];
    assign twice     = {own, 1'b0};
    assign twice_mod = (twice >= 5'd10) ? 4'(twice - 5'd10) : twice[3:0];
    // 2X: (2*own mod 10) plus carry of one when the lower digit is 5 or more
    assign x2[4*i +: 4] = twice_mod + {3'b000, (low >= 4'd5)};
    // 5X: 5 when own digit is odd, plus half of the lower digit
    assign x5[4*i +: 4] = (own[0] ? 4'd5 : 4'd0) + {1'b0, low[3:1]};
  end

endmodule

// File: rtl/dmul_bcd_add.sv
// Ripple decimal adder; the carry out of the top digit is dropped (modulo 10^ND).
module dmul_bcd_add #(
  parameter int ND = 18
) (
  input  logic [4*ND-1:0] a,
  input  logic [4*ND-1:0] b,
  input  logic            cin,
  output logic [4*ND-1:0] sum
);
  logic [ND:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [4:0] raw;
    logic [4:0] fix;
    assign raw    = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0000, c[i]};
    assign fix    = raw + 5'd6;
    assign c[i+1] = (raw > 5'd9);
    assign sum[4*i +: 4] = c[i+1] ? fix[3:0] : raw[3:0];
  end

endmodule

// File: rtl/dmul_pp_select.sv
// Chooses the two multiples for one multiplier digit and prepares them for the adders.
module dmul_pp_select
  import dmul_pkg::*;
#(
  parameter int DIGITS = 16,
  parameter int ACC    = DIGITS + 2
) (
  input  bcd_t                    digit,
  input  logic [4*DIGITS-1:0]     x,
  input  logic [4*(DIGITS+1)-1:0] x2,
  input  logic [4*(DIGITS+1)-1:0] x5,
  output logic [4*ACC-1:0]        hi_op,
  output logic [4*ACC-1:0]        lo_op,
  output logic                    lo_cin
);
  localparam int AW = 4 * ACC;

  pp_sel_t       sel;
  logic [AW-1:0] x1_e, x2_e, x5_e, x10_e;
  logic [AW-1:0] lo_mag;
  logic [AW-1:0] lo_nines;

  assign sel   = split_digit(digit);
  assign x1_e  = AW'(x);
  assign x2_e  = AW'(x2);
  assign x5_e  = AW'(x5);
  assign x10_e = AW'({x, 4'h0});

  always_comb begin
    case (sel.hi)
      HI_X2:   hi_op = x2_e;
      HI_X5:   hi_op = x5_e;
      HI_X10:  hi_op = x10_e;
      default: hi_op = '0;
    endcase
    case (sel.lo)
      LO_X1:   lo_mag = x1_e;
      LO_X2:   lo_mag = x2_e;
      default: lo_mag = '0;
    endcase
  end

  for (genvar i = 0; i < ACC; i++) begin : g_nine
    assign lo_nines[4*i +: 4] = 4'd9 - lo_mag[4*i +: 4];
  end

  // negative multiple: nine's complement across the full width plus one
  assign lo_op  = sel.lo_neg ? lo_nines : lo_mag;
  assign lo_cin = sel.lo_neg;

endmodule

// File: rtl/dec_mul_iter.sv
module dec_mul_iter
  import dmul_pkg::*;
#(
  parameter int DIGITS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [4*DIGITS-1:0]     multiplicand,
  input  logic [4*DIGITS-1:0]     multiplier,
  output logic                    busy,
  output logic                    done,
  output logic [8*DIGITS-1:0]     product
);
  localparam int ACC = DIGITS + 2;
  localparam int XW  = 4 * DIGITS;
  localparam int AW  = 4 * ACC;
  localparam int PW  = 8 * DIGITS;
  localparam int CW  = $clog2(DIGITS + 1);

  dmul_state_e         state;
  logic [XW-1:0]       x_q;
  logic [XW-1:0]       m_q;
  logic [AW-1:0]       acc_q;
  logic [XW-1:0]       low_q;
  logic [CW-1:0]       left_q;
  logic [CW-1:0]       steps_q;
  logic [PW-1:0]       prod_q;
  logic                done_q;

  // index of the highest nonzero digit plus one
  function automatic logic [CW-1:0] sig_digits(input logic [XW-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] != 4'h0) n = CW'(i + 1);
    end
    return n;
  endfunction

  logic [CW-1:0] n_in;
  assign n_in = sig_digits(multiplier);

  // multiples of the held multiplicand
  logic [4*(DIGITS+1)-1:0] x2, x5;
  dmul_multiples #(.DIGITS(DIGITS)) u_mult (
    .x  (x_q),
    .x2 (x2),
    .x5 (x5)
  );

  logic [AW-1:0] hi_op, lo_op;
  logic          lo_cin;
  dmul_pp_select #(.DIGITS(DIGITS), .ACC(ACC)) u_sel (
    .digit  (m_q[3:0]),
    .x      (x_q),
    .x2     (x2),
    .x5     (x5),
    .hi_op  (hi_op),
    .lo_op  (lo_op),
    .lo_cin (lo_cin)
  );

  logic [AW-1:0] part_sum, step_sum;
  dmul_bcd_add #(.ND(ACC)) u_add_hi (
    .a   (acc_q),
    .b   (hi_op),
    .cin (1'b0),
    .sum (part_sum)
  );
  dmul_bcd_add #(.ND(ACC)) u_add_lo (
    .a   (part_sum),
    .b   (lo_op),
    .cin (lo_cin),
    .sum (step_sum)
  );

  // final alignment: high digits sit in acc, low N digits at the top of low_q
  logic [PW-1:0] joined;
  logic [CW-1:0] skip;
  logic [PW-1:0] aligned;
  assign joined  = {acc_q[XW-1:0], low_q};
  assign skip    = CW'(DIGITS) - steps_q;
  assign aligned = joined >> {skip, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      x_q     <= '0;
      m_q     <= '0;
      acc_q   <= '0;
      low_q   <= '0;
      left_q  <= '0;
      steps_q <= '0;
      prod_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            x_q     <= multiplicand;
            m_q     <= multiplier;
            acc_q   <= '0;
            low_q   <= '0;
            left_q  <= n_in;
            steps_q <= n_in;
            state   <= (n_in == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q  <= {4'h0, step_sum[AW-1:4]};
          low_q  <= {step_sum[3:0], low_q[XW-1:4]};
          m_q    <= {4'h0, m_q[XW-1:4]};
          left_q <= left_q - 1'b1;
          if (left_q == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          prod_q <= aligned;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign product  = prod_q;

endmodule

// File: rtl/dec_mul_iter_chk.sv
module dec_mul_iter_chk #(
  parameter int DIGITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                busy,
  input logic                done,
  input logic [8*DIGITS-1:0] product
);
  function automatic logic all_bcd(input logic [8*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 2*DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // R4
  ready_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !busy);

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

  // R9
  product_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> all_bcd(product));

endmodule

bind dec_mul_iter dec_mul_iter_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .product  (product)
);

// File: tb/sim_dec_mul_iter.sv
module sim_dec_mul_iter;
  localparam int  D      = 16;
  localparam time PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [4*D-1:0] multiplicand = '0;
  logic [4*D-1:0] multiplier = '0;
  logic           busy;
  logic           done;
  logic [8*D-1:0] product;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  dec_mul_iter #(.DIGITS(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [127:0] to_bin(input logic [4*D-1:0] v);
    logic [127:0] r = '0;
    for (int i = D - 1; i >= 0; i--) r = r * 10 + 128'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [8*D-1:0] to_bcd(input logic [127:0] b);
    logic [8*D-1:0] v = '0;
    for (int i = 0; i < 2*D; i++) begin
      v[4*i +: 4] = 4'(b % 10);
      b = b / 10;
    end
    return v;
  endfunction

  function automatic int count_sig(input logic [4*D-1:0] v);
    int n = 0;
    for (int i = 0; i < D; i++) if (v[4*i +: 4] != 4'h0) n = i + 1;
    return n;
  endfunction

  function automatic bit digits_ok(input logic [8*D-1:0] v);
    for (int i = 0; i < 2*D; i++) if (v[4*i +: 4] > 4'd9) return 0;
    return 1;
  endfunction

  function automatic logic [4*D-1:0] rand_bcd(input int nsig);
    logic [4*D-1:0] v = '0;
    for (int i = 0; i < nsig; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one operation: latency, product, digit validity, pulse shape and hold
  task automatic run_mul(input logic [4*D-1:0] a, input logic [4*D-1:0] b, input string req);
    int k;
    logic [8*D-1:0] exp_p;
    exp_p = to_bcd(to_bin(a) * to_bin(b));
    @(negedge clk);
    check(in_ready == 1'b1, "R4", "ready before request", 128'(in_ready), 128'd1);
    multiplicand = a;
    multiplier   = b;
    in_valid     = 1'b1;
    @(negedge clk);
    in_valid     = 1'b0;
    multiplicand = '0;
    multiplier   = '0;
    check(busy == 1'b1 && in_ready == 1'b0, "R4", "busy after accept",
          128'({busy, in_ready}), 128'b10);
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(product == exp_p, req, "product", product, exp_p);
    check(k == count_sig(b) + 1, "R3", "latency", 128'(k), 128'(count_sig(b) + 1));
    check(digits_ok(product), "R9", "bcd digits", product, exp_p);
    check(busy == 1'b0, "R4", "busy low with done", 128'(busy), 128'd0);
    @(negedge clk);
    check(done == 1'b0, "R6", "done one cycle", 128'(done), 128'd0);
    check(product == exp_p, "R6", "product hold", product, exp_p);
  endtask

  task automatic t_reset;
    check(busy == 1'b0 && done == 1'b0 && in_ready == 1'b1, "R1", "control after reset",
          128'({busy, done, in_ready}), 128'b001);
    check(product == '0, "R1", "product after reset", product, 128'd0);
  endtask

  task automatic t_basic;
    run_mul(64'h0000_0000_0000_0123, 64'h0000_0000_0000_0456, "R2");
    run_mul(64'h0000_0000_0000_0007, 64'h0000_0000_0000_0001, "R2");
    run_mul(64'h1234_5678_9012_3456, 64'h0000_0000_0765_4321, "R2");
    run_mul(64'h5555_5555_5555_5555, 64'h0000_0000_7654_3210, "R2");
  endtask

  task automatic t_negative;
    run_mul(64'h9999_9999_9999_9999, 64'h9999_9999_9999_9999, "R7");
    run_mul(64'h0000_0000_0000_0001, 64'h8888_8888_8888_8888, "R7");
    run_mul(64'h9595_9595_9595_9595, 64'h9898_9898_9898_9898, "R7");
    run_mul(64'h0000_0000_0000_0000, 64'h9999_9999_9999_9999, "R8");
  endtask

  task automatic t_zero;
    run_mul(64'h9999_9999_9999_9999, 64'h0000_0000_0000_0000, "R8");
    run_mul(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, "R8");
    run_mul(64'h0000_0000_4321_0000, 64'h1000_0000_0000_0000, "R3");
    run_mul(64'h0000_0000_4321_0000, 64'h0000_0000_0000_0009, "R3");
  endtask

  task automatic t_busy_ignore;
    logic [8*D-1:0] exp_p;
    int k;
    exp_p = to_bcd(to_bin(64'h2468_0246_8024_6802) * to_bin(64'h9753_1975_3197_5319));
    @(negedge clk);
    multiplicand = 64'h2468_0246_8024_6802;
    multiplier   = 64'h9753_1975_3197_5319;
    in_valid     = 1'b1;
    @(negedge clk);
    multiplicand = 64'h1111_1111_1111_1111;
    multiplier   = 64'h3333_3333_3333_3333;
    for (int i = 0; i < 4; i++) begin
      check(in_ready == 1'b0, "R5", "ready low while busy", 128'(in_ready), 128'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(product == exp_p, "R5", "result unaffected", product, exp_p);
    k = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (done || busy) k++;
    end
    check(k == 0, "R5", "no extra operation", 128'(k), 128'd0);
    check(product == exp_p, "R6", "product held idle", product, exp_p);
  endtask

  task automatic t_random;
    for (int i = 0; i < 40; i++) begin
      run_mul(rand_bcd($urandom_range(1, D)), rand_bcd($urandom_range(0, D)), "R2");
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_negative;
    t_zero;
    t_busy_ignore;
    t_random;
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule